// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block runs the transfers of a single DMA channel. The channel's work is described by four-word descriptors held in system memory. Word 0 is the last source address, word 1 is the last destination address, word 2 is a configuration word and word 3 is unused padding. Every descriptor names end addresses and a count of remaining items, not start addresses. The sequencer therefore derives each address from the matching end pointer and the count that is still outstanding.

Firmware enables the channel with a start pulse, which also picks the primary or the alternate descriptor. When a request is seen, the sequencer:
- fetches the selected descriptor;
- moves a burst of byte, halfword or word items through a synchronous memory port with a one-cycle read latency;
- writes the configuration word back with the count reduced.

Four modes are handled:
- **Stop**: the channel shuts off.
- **Basic**: one burst per request.
- **Auto-request**: one request drains the whole descriptor, pausing between bursts for re-arbitration.
- **Ping-pong**: completion flips the channel to the other descriptor.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the channel is disabled, `altSelect` is 0, `irq`, `done` and `cfgErr` are low, and the memory port is idle.
- R2: The descriptor is fetched from `baseAddr + 256*altSelect + 16*CHAN_ID`, reading word 0 (source end), then word 1 (destination end), then word 2 (configuration); only word 2 is ever written back.
- R3: Configuration bits [27:26] and [31:30] are the source and destination increment codes (00 byte, 01 halfword, 10 word, 11 fixed). Each item address is `end - (remaining << code)`, where `remaining` is the count before the move; code 11 keeps the end address.
- R4: Bits [25:24] and [29:28] give the source and destination sizes (00 byte, 01 halfword, 10 word). The item is taken from the source byte lanes selected by the source address and written to the destination lanes selected by the destination address, with matching byte enables.
- R5: Bits [13:4] hold NCOUNT. A descriptor moves NCOUNT+1 items, and after each burst the configuration word in memory holds the remaining count.
- R6: With mode field [2:0] = 1 (basic), each request moves 2^P items, where P is bits [17:14], or fewer if fewer remain.
- R7: With mode 2 (auto-request), a single request moves all items. The descriptor is fetched again every 2^P items, after a one-cycle idle gap on the memory port.
- R8: After the last item of a basic or auto-request descriptor, the configuration word is written with mode 0 and NCOUNT 0, the channel disables itself, and `done` and `irq` pulse for one cycle.
- R9: With mode 3 (ping-pong), completion writes mode 0 and NCOUNT 0, toggles `altSelect`, pulses `irq` without `done`, and leaves the channel enabled.
- R10: A request that fetches a descriptor with mode 0 disables the channel, writes nothing and raises no interrupt.
- R11: A descriptor with a size code of 11, unequal source and destination sizes, or a mode above 3 pulses `cfgErr`, disables the channel and leaves memory untouched.
- R12: Requests are ignored while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | ADDR_W | Descriptor table base, 256-byte aligned |
| chanStart | input | 1 | Pulse: enable the channel (accepted when idle) |
| startAlt | input | 1 | Descriptor chosen by `chanStart` (1 = alternate) |
| dmaReq | input | 1 | Granted transfer request |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address of the access |
| memBe | output | 4 | Write byte enables |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read |
| chanEnabled | output | 1 | Channel enable state |
| altSelect | output | 1 | Descriptor in use (1 = alternate) |
| irq | output | 1 | One-cycle descriptor-complete pulse |
| done | output | 1 | One-cycle pulse when the channel finishes and disables |
| cfgErr | output | 1 | One-cycle bad-descriptor pulse |

## Verification
The bound checker watches rules that must hold on every cycle:
- the memory port is silent while the channel is disabled;
- byte enables on writes cover one, two or four lanes;
- `done` and `cfgErr` are never seen with the channel still enabled;
- `altSelect` changes only on a start or a completion interrupt.

The address arithmetic, byte-lane placement, per-request burst length, per-burst count write-back and the ping-pong hand-over depend on memory contents, so only the bench's scenarios show them. The bench compares the whole memory image, and the number of requests each transfer needed, against a reference model.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int CNT_W   = 10;
  localparam int BURST_W = 16;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_AUTO  = 3'd2;
  localparam logic [2:0] MODE_PING  = 3'd3;

  typedef enum logic [2:0] {
    SEL_D0, SEL_D1, SEL_D2, SEL_SRC, SEL_DST
  } addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capSrc;
    logic     capDst;
    logic     capCfg;
    logic     step;
    logic     memEn;
    logic     memWe;
    logic     finalWb;
    addrSel_e addrSel;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic [2:0] mode;
    logic       sizeBad;
    logic       countZero;
    logic       burstLast;
  } dpStat_t;
endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CHAN_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              altSel,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  output dpStat_t           stat
);
  localparam logic [ADDR_W-1:0] CHAN_OFF = ADDR_W'(CHAN_ID * 16);
  localparam logic [ADDR_W-1:0] ALT_OFF  = ADDR_W'(256);

  logic [ADDR_W-1:0] srcEnd, dstEnd, srcAddr, dstAddr, descAddr;
  logic [31:0]       cfgWord, item, shifted;
  logic [CNT_W-1:0]  count;
  logic [BURST_W-1:0] burstCnt;
  logic [1:0] srcInc, dstInc, srcSize, dstSize;
  logic [3:0] rpow;

  assign dstInc  = cfgWord[31:30];
  assign dstSize = cfgWord[29:28];
  assign srcInc  = cfgWord[27:26];
  assign srcSize = cfgWord[25:24];
  assign rpow    = cfgWord[17:14];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcEnd   <= '0;
      dstEnd   <= '0;
      cfgWord  <= '0;
      count    <= '0;
      burstCnt <= '0;
    end else begin
      if (ctl.capSrc) srcEnd <= memRdata[ADDR_W-1:0];
      if (ctl.capDst) dstEnd <= memRdata[ADDR_W-1:0];
      if (ctl.capCfg) begin
        cfgWord  <= memRdata;
        count    <= memRdata[13:4];
        burstCnt <= '0;
      end else if (ctl.step) begin
        if (count != '0) count <= count - 1'b1;
        burstCnt <= burstCnt + 1'b1;
      end
    end
  end

  // address = end - (remaining << increment), fixed when code is 11
  always_comb begin
    srcAddr = (srcInc == 2'b11) ? srcEnd : srcEnd - (ADDR_W'(count) << srcInc);
    dstAddr = (dstInc == 2'b11) ? dstEnd : dstEnd - (ADDR_W'(count) << dstInc);
  end

  assign descAddr = baseAddr + (altSel ? ALT_OFF : '0) + CHAN_OFF;

  always_comb begin
    shifted = memRdata >> {srcAddr[1:0], 3'b000};
    case (srcSize)
      2'd0:    item = shifted & 32'h0000_00FF;
      2'd1:    item = shifted & 32'h0000_FFFF;
      default: item = shifted;
    endcase
  end

  always_comb begin
    memBe    = 4'hF;
    memWdata = ctl.finalWb ? {cfgWord[31:14], {CNT_W{1'b0}}, cfgWord[3], MODE_STOP}
                           : {cfgWord[31:14], count, cfgWord[3:0]};
    case (ctl.addrSel)
      SEL_D0:  memAddr = descAddr;
      SEL_D1:  memAddr = descAddr + ADDR_W'(4);
      SEL_D2:  memAddr = descAddr + ADDR_W'(8);
      SEL_SRC: memAddr = srcAddr;
      default: begin
        memAddr  = dstAddr;
        memWdata = item << {dstAddr[1:0], 3'b000};
        case (dstSize)
          2'd0:    memBe = 4'b0001 << dstAddr[1:0];
          2'd1:    memBe = 4'b0011 << dstAddr[1:0];
          default: memBe = 4'b1111;
        endcase
      end
    endcase
  end

  assign stat.mode      = cfgWord[2:0];
  assign stat.sizeBad   = (srcSize == 2'b11) || (dstSize == 2'b11) || (srcSize != dstSize);
  assign stat.countZero = (count == '0);
  assign stat.burstLast = (burstCnt == ((BURST_W'(1) << rpow) - BURST_W'(1)));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chanStart,
  input  logic    startAlt,
  input  logic    dmaReq,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    chanEn,
  output logic    altSel,
  output logic    irq,
  output logic    done,
  output logic    cfgErr
);
  typedef enum logic [3:0] {
    S_IDLE, S_LDS, S_LDD, S_LDC, S_CHK, S_DEC, S_MRD, S_MWR, S_WB, S_WBF
  } state_e;

  state_e state, nxt;
  logic   autoPend, badDesc;

  assign badDesc = stat.sizeBad || (stat.mode > MODE_PING);

  always_comb begin
    ctl         = '0;
    ctl.addrSel = SEL_D0;
    nxt         = state;
    case (state)
      S_IDLE: if (!chanStart && chanEn && (dmaReq || autoPend)) nxt = S_LDS;
      S_LDS: begin ctl.memEn = 1'b1; ctl.addrSel = SEL_D0; nxt = S_LDD; end
      S_LDD: begin ctl.memEn = 1'b1; ctl.addrSel = SEL_D1; ctl.capSrc = 1'b1; nxt = S_LDC; end
      S_LDC: begin ctl.memEn = 1'b1; ctl.addrSel = SEL_D2; ctl.capDst = 1'b1; nxt = S_CHK; end
      S_CHK: begin ctl.capCfg = 1'b1; nxt = S_DEC; end
      S_DEC: nxt = (stat.mode == MODE_STOP || badDesc) ? S_IDLE : S_MRD;
      S_MRD: begin ctl.memEn = 1'b1; ctl.addrSel = SEL_SRC; nxt = S_MWR; end
      S_MWR: begin
        ctl.memEn = 1'b1; ctl.memWe = 1'b1; ctl.addrSel = SEL_DST; ctl.step = 1'b1;
        if (stat.countZero)      nxt = S_WBF;
        else if (stat.burstLast) nxt = S_WB;
        else                     nxt = S_MRD;
      end
      S_WB:  begin ctl.memEn = 1'b1; ctl.memWe = 1'b1; ctl.addrSel = SEL_D2; nxt = S_IDLE; end
      S_WBF: begin
        ctl.memEn = 1'b1; ctl.memWe = 1'b1; ctl.addrSel = SEL_D2; ctl.finalWb = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      chanEn   <= 1'b0;
      altSel   <= 1'b0;
      autoPend <= 1'b0;
      irq      <= 1'b0;
      done     <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      state  <= nxt;
      irq    <= 1'b0;
      done   <= 1'b0;
      cfgErr <= 1'b0;
      case (state)
        S_IDLE: begin
          if (chanStart) begin
            chanEn   <= 1'b1;
            altSel   <= startAlt;
            autoPend <= 1'b0;
          end else if (nxt == S_LDS) begin
            autoPend <= 1'b0;
          end
        end
        S_DEC: begin
          if (stat.mode == MODE_STOP) begin
            chanEn <= 1'b0;
          end else if (badDesc) begin
            chanEn <= 1'b0;
            cfgErr <= 1'b1;
          end
        end
        S_WB: if (stat.mode == MODE_AUTO) autoPend <= 1'b1;
        S_WBF: begin
          irq <= 1'b1;
          if (stat.mode == MODE_PING) begin
            altSel <= ~altSel;
          end else begin
            chanEn <= 1'b0;
            done   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CHAN_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              chanStart,
  input  logic              startAlt,
  input  logic              dmaReq,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              chanEnabled,
  output logic              altSelect,
  output logic              irq,
  output logic              done,
  output logic              cfgErr
);
  dpCtl_t  ctl;
  dpStat_t stat;

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanStart(chanStart), .startAlt(startAlt),
    .dmaReq(dmaReq), .stat(stat), .ctl(ctl), .chanEn(chanEnabled),
    .altSel(altSelect), .irq(irq), .done(done), .cfgErr(cfgErr)
  );

  dma_seq_dp #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseAddr(baseAddr), .altSel(altSelect),
    .memRdata(memRdata), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .stat(stat)
  );

  assign memEn = ctl.memEn;
  assign memWe = ctl.memWe;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       chanStart,
  input logic       memEn,
  input logic       memWe,
  input logic [3:0] memBe,
  input logic       chanEnabled,
  input logic       altSelect,
  input logic       irq,
  input logic       done,
  input logic       cfgErr
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> chanEnabled); // R12
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memBe) == 1 || $countones(memBe) == 2 || $countones(memBe) == 4)); // R4
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!chanEnabled && irq)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R8
  AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!chanEnabled && !irq)); // R11
  AST_ALT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(altSelect) |-> (irq || $past(chanStart))); // R9
endmodule

bind dma_desc_seq dma_seq_chk u_chk (.*);

// File: tb/tb_dma_desc_seq.sv
module tb_dma_desc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CHAN = 1;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 0, rstN = 0, chanStart = 0, startAlt = 0, dmaReq = 0;
  logic memEn, memWe, chanEnabled, altSelect, irq, done, cfgErr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;

  logic [31:0] mem    [0:1023];
  logic [31:0] expMem [0:1023];
  int checks = 0, fails = 0;
  int dataWrites = 0, descReads = 0, irqCnt = 0, doneCnt = 0, errCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_seq #(.ADDR_W(32), .CHAN_ID(CHAN)) dut (
    .clk(clk), .rstN(rstN), .baseAddr(BASE), .chanStart(chanStart), .startAlt(startAlt),
    .dmaReq(dmaReq), .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .chanEnabled(chanEnabled),
    .altSelect(altSelect), .irq(irq), .done(done), .cfgErr(cfgErr)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[11:2]][8*b +: 8] <= memWdata[8*b +: 8];
      end else begin
        memRdata <= mem[memAddr[11:2]];
      end
    end
  end

  function automatic logic [31:0] descAt(input bit alt, input int w);
    return BASE + (alt ? 32'd256 : 32'd0) + CHAN * 16 + 4 * w;
  endfunction

  always @(negedge clk) begin
    if (memEn && memWe && memAddr >= 32'h400) dataWrites++;
    if (memEn && !memWe && (memAddr == descAt(0, 0) || memAddr == descAt(1, 0))) descReads++;
    if (irq) irqCnt++;
    if (done) doneCnt++;
    if (cfgErr) errCnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input logic [1:0] dInc, dSz, sInc, sSz,
                                        input logic [3:0] rp, input logic [9:0] n,
                                        input logic [2:0] md);
    return {dInc, dSz, sInc, sSz, 6'b0, rp, n, 1'b0, md};
  endfunction

  function automatic logic [31:0] finCfg(input logic [31:0] c);
    return {c[31:14], 10'd0, c[3], 3'b000};
  endfunction

  task automatic putDesc(input bit alt, input logic [31:0] se, de, cfg);
    mem[descAt(alt, 0) >> 2] = se;
    mem[descAt(alt, 1) >> 2] = de;
    mem[descAt(alt, 2) >> 2] = cfg;
    mem[descAt(alt, 3) >> 2] = 32'h0;
  endtask

  task automatic snap();
    for (int i = 0; i < 1024; i++) expMem[i] = mem[i];
  endtask

  // reference: copy the descriptor's items into expMem and close the descriptor
  task automatic refMove(input bit alt);
    logic [31:0] se, de, c, sa, da, v;
    int n, sz, si, di;
    se = expMem[descAt(alt, 0) >> 2];
    de = expMem[descAt(alt, 1) >> 2];
    c  = expMem[descAt(alt, 2) >> 2];
    n = int'(c[13:4]); sz = int'(c[25:24]); si = int'(c[27:26]); di = int'(c[31:30]);
    for (int i = 0; i <= n; i++) begin
      sa = (si == 3) ? se : se - (32'(n - i) << si);
      da = (di == 3) ? de : de - (32'(n - i) << di);
      v = expMem[sa >> 2] >> (8 * sa[1:0]);
      for (int b = 0; b < (1 << sz); b++)
        expMem[da >> 2][8 * (da[1:0] + b) +: 8] = v[8 * b +: 8];
    end
    expMem[descAt(alt, 2) >> 2] = finCfg(c);
  endtask

  function automatic int memDiffs();
    int d = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== expMem[i]) d++;
    return d;
  endfunction

  task automatic start(input bit alt);
    @(negedge clk); chanStart = 1; startAlt = alt;
    @(negedge clk); chanStart = 0;
  endtask

  task automatic runReq();
    int quiet = 0;
    @(negedge clk); dmaReq = 1;
    @(negedge clk); dmaReq = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = memEn ? 0 : quiet + 1;
    end
  endtask

  task automatic runAll(output int reqs);
    reqs = 0;
    while (chanEnabled && reqs < 200) begin runReq(); reqs++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int reqs, w0, d0, i0;
    logic [31:0] cfg;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!chanEnabled && !altSelect, "R1 enable/alt after reset", {chanEnabled, altSelect}, 0);
    chk(!irq && !done && !cfgErr && !memEn, "R1 pulses/port after reset", {irq, done, cfgErr, memEn}, 0);
    rstN = 1;
    @(negedge clk);

    // R12: request with channel disabled
    putDesc(0, 32'h400, 32'h800, mkCfg(2, 2, 2, 2, 0, 0, 1));
    snap();
    runReq();
    chk(dataWrites == 0 && descReads == 0, "R12 request ignored while disabled", dataWrites, 0);

    // R10: stop mode
    putDesc(0, 32'h400, 32'h800, mkCfg(2, 2, 2, 2, 0, 3, 0));
    snap(); start(0); runReq();
    chk(!chanEnabled && irqCnt == 0, "R10 stop disables silently", {chanEnabled, 8'(irqCnt)}, 0);
    chk(memDiffs() == 0 && dataWrites == 0, "R10 no memory change", memDiffs(), 0);

    // R5 R6 R2: basic words, 6 items, 2 per request
    for (int i = 0; i < 16; i++) mem[(32'h400 >> 2) + i] = 32'hA000_0000 + i;
    cfg = mkCfg(2, 2, 2, 2, 1, 5, 1);
    putDesc(0, 32'h414, 32'h814, cfg);
    snap(); refMove(0);
    start(0);
    w0 = dataWrites; d0 = descReads;
    runReq();
    chk(dataWrites - w0 == 2, "R6 basic burst length", dataWrites - w0, 2);
    chk(descReads - d0 == 1, "R2 one primary fetch per request", descReads - d0, 1);
    chk(mem[descAt(0, 2) >> 2] == mkCfg(2, 2, 2, 2, 1, 3, 1), "R5 count written back",
        mem[descAt(0, 2) >> 2], mkCfg(2, 2, 2, 2, 1, 3, 1));
    runAll(reqs);
    chk(reqs == 2, "R6 remaining requests", reqs, 2);
    chk(memDiffs() == 0, "R3 R5 basic memory image", memDiffs(), 0);
    chk(!chanEnabled && doneCnt == 1 && irqCnt == 1, "R8 completion pulses", {chanEnabled, 8'(doneCnt), 8'(irqCnt)}, 32'h0101);
    w0 = dataWrites; runReq();
    chk(dataWrites == w0, "R12 ignored after completion", dataWrites - w0, 0);

    // R7 R4: auto-request bytes, 10 items, bursts of 4, alternate descriptor
    cfg = mkCfg(0, 0, 0, 0, 2, 9, 2);
    putDesc(1, 32'h409, 32'h903, cfg);
    snap(); refMove(1);
    d0 = descReads; i0 = irqCnt;
    start(1); runAll(reqs);
    chk(reqs == 1, "R7 single request", reqs, 1);
    chk(descReads - d0 == 3, "R7 refetch every burst", descReads - d0, 3);
    chk(memDiffs() == 0, "R4 R2 byte lanes from alternate", memDiffs(), 0);
    chk(irqCnt - i0 == 1 && !chanEnabled, "R8 auto completion", irqCnt - i0, 1);

    // R3: fixed source, halfwords
    mem[32'h402 >> 2] = 32'hBEEF_1234;
    putDesc(0, 32'h402, 32'hA06, mkCfg(1, 1, 3, 1, 2, 3, 2));
    snap(); refMove(0);
    start(0); runAll(reqs);
    chk(memDiffs() == 0 && mem[32'hA00 >> 2] == 32'hBEEF_BEEF, "R3 fixed source address",
        mem[32'hA00 >> 2], 32'hBEEF_BEEF);

    // R9: ping-pong
    putDesc(0, 32'h404, 32'hB04, mkCfg(2, 2, 2, 2, 0, 1, 3));
    putDesc(1, 32'h40C, 32'hB1C, mkCfg(2, 2, 2, 2, 1, 2, 3));
    snap(); refMove(0);
    i0 = irqCnt; d0 = doneCnt;
    start(0); runReq(); runReq();
    chk(altSelect && chanEnabled, "R9 switched to alternate", {altSelect, chanEnabled}, 2'b11);
    chk(irqCnt - i0 == 1 && doneCnt == d0, "R9 irq without done", irqCnt - i0, 1);
    chk(memDiffs() == 0, "R9 primary closed", memDiffs(), 0);
    refMove(1);
    runReq(); runReq();
    chk(!altSelect && chanEnabled && memDiffs() == 0, "R9 alternate done, back to primary",
        {altSelect, chanEnabled}, 2'b01);
    w0 = dataWrites; runReq();
    chk(!chanEnabled && dataWrites == w0 && irqCnt - i0 == 2, "R10 ping-pong stops on cleared descriptor",
        chanEnabled, 0);

    // R11: mismatched sizes, then reserved size
    putDesc(0, 32'h404, 32'hB04, mkCfg(2, 2, 2, 1, 0, 2, 1));
    snap(); i0 = errCnt; w0 = dataWrites;
    start(0); runReq();
    chk(errCnt - i0 == 1 && !chanEnabled && dataWrites == w0 && memDiffs() == 0,
        "R11 size mismatch", errCnt - i0, 1);
    putDesc(0, 32'h404, 32'hB04, mkCfg(3, 3, 3, 3, 0, 2, 2));
    snap();
    start(0); runReq();
    chk(errCnt - i0 == 2 && memDiffs() == 0, "R11 reserved size", errCnt - i0, 2);

    // random transfers against the reference model
    for (int t = 0; t < 10; t++) begin
      logic [1:0] sz, si;
      logic [3:0] rp;
      logic [9:0] n;
      logic [2:0] md;
      bit alt;
      int expReqs;
      sz = 2'($urandom_range(0, 2));
      si = ($urandom_range(0, 3) == 0) ? 2'b11 : sz;
      rp = 4'($urandom_range(0, 3));
      n  = 10'($urandom_range(0, 12));
      md = 3'($urandom_range(1, 2));
      alt = bit'($urandom_range(0, 1));
      for (int i = 0; i < 128; i++) mem[(32'h400 >> 2) + i] = $urandom;
      cfg = mkCfg(sz, sz, si, sz, rp, n, md);
      putDesc(alt, 32'h500, 32'h900, cfg);
      snap(); refMove(alt);
      expReqs = (md == 3'd2) ? 1 : ((int'(n) + (1 << rp)) >> rp);
      start(alt); runAll(reqs);
      chk(memDiffs() == 0, "R3 R4 R5 random transfer image", memDiffs(), 0);
      chk(reqs == expReqs, "R6 R7 random request count", reqs, expReqs);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule